// File: doc/BRIEF.md
# Packet-Filter VM Instruction Decoder

This block sits between the instruction fetch of a packet-filter virtual machine and its execute stage. It accepts a stream of 64-bit instruction slots over a valid/ready handshake and presents, for each instruction, a registered set of decoded control fields over a second valid/ready handshake. Register-file access, execution, memory traffic and program-counter update are left to the stages around it.

Each slot is split into an opcode byte, a register byte, a 16-bit offset and a 32-bit immediate. The opcode byte is read in one of two ways, depending on its class. For arithmetic and jump classes it gives an operation code and an operand select. For load/store classes it gives an addressing mode and an access size. A static mode input chooses which nibble of the register byte names the destination register.

The wide-immediate load spans two slots. The decoder holds the first slot internally and emits a single decoded operation once the second slot arrives. Reserved or unknown encodings are still emitted, with an illegal flag set, so the pipeline never stalls on them.

Top module: `pfvm_insn_decoder`

## Requirements
- R1: A slot carries the opcode in bits 7:0, the register byte in bits 15:8, the offset in bits 31:16 and the immediate in bits 63:32. The decoded class equals opcode bits 2:0.
- R2: With `bigEndMode`=0 the destination register is register-byte bits 3:0 and the source register is bits 7:4. With `bigEndMode`=1 the two nibbles are swapped.
- R3: For classes 4 to 7 (arithmetic, jump, 32-bit jump, 64-bit arithmetic), `outAluCode` is opcode bits 7:4 and `outSrcSel` is opcode bit 3 (0 selects the immediate, 1 selects the source register). In these classes `outLsMode` and `outLsSize` read zero.
- R4: For classes 0 to 3 (load, register load, store, register store), `outLsMode` is opcode bits 7:5 and `outLsSize` is opcode bits 4:3 (0 = 4 bytes, 1 = 2, 2 = 1, 3 = 8). In these classes `outAluCode` and `outSrcSel` read zero.
- R5: `outOffset` is the offset sign-extended to 64 bits. `outImmSext` is the immediate sign-extended to 64 bits. `outImmRaw` is the unmodified 32-bit immediate.
- R6: A slot with opcode 0x18 starts a two-slot load. The next accepted slot completes it, and one operation is emitted with `outLen2`=1 and `outImm64` = {second slot bits 63:32, first slot bits 63:32}. All other decoded fields come from the first slot. A single-slot operation has `outLen2`=0 and `outImm64` equal to `outImmSext`.
- R7: `outIllegal` is set, and the operation is still emitted, in three cases: a load/store class with mode 4, 5 or 7; an arithmetic or jump class with operation code 14 or 15; or a two-slot load whose second slot has nonzero bits 31:0.
- R8: `inReady` is high when no output is pending or the pending output is being taken. While `outValid` is high and `outReady` is low, `outValid` stays high and every decoded output stays unchanged.
- R9: A synchronous reset clears `outValid` and discards a held first slot. The next slot after reset is decoded as a fresh instruction.
- R10: Accepting the first slot of a two-slot load produces no output until the second slot is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bigEndMode | input | 1 | Register-nibble layout select |
| inValid | input | 1 | Slot offered |
| inReady | output | 1 | Slot taken this cycle when inValid is high |
| inWord | input | 64 | Instruction slot |
| outValid | output | 1 | Decoded operation available |
| outReady | input | 1 | Consumer takes the operation |
| outOpcode | output | 8 | Raw opcode byte |
| outClass | output | 3 | Instruction class |
| outAluCode | output | 4 | Operation code (arithmetic/jump classes) |
| outSrcSel | output | 1 | Second operand select (arithmetic/jump classes) |
| outLsMode | output | 3 | Addressing mode (load/store classes) |
| outLsSize | output | 2 | Access size (load/store classes) |
| outDst | output | 4 | Destination register index |
| outSrc | output | 4 | Source register index |
| outOffset | output | 64 | Sign-extended offset |
| outImmSext | output | 64 | Sign-extended immediate |
| outImmRaw | output | 32 | Raw immediate |
| outImm64 | output | 64 | Wide immediate |
| outLen2 | output | 1 | Operation occupied two slots |
| outIllegal | output | 1 | Reserved or unknown encoding |

## Verification
The main decode is driven with one opcode from each class. Both operand-select values and several load/store modes and sizes are included, which separates the two ways of splitting the opcode byte. The same slot is decoded under both nibble layouts to expose a missing swap. Offsets and immediates with the sign bit set and with it clear show whether sign extension is applied. The reserved modes 4, 5 and 7 and the unused operation codes are checked against legal neighbours to confirm the illegal flag. Two-slot loads with a clean and with a dirty second slot are run, together with a reset between the two slots and a stalled consumer, to check how the pair is joined and how output is held.

// File: rtl/pfvm_dec_pkg.sv
package pfvm_dec_pkg;
  localparam int SLOT_W = 64;
  localparam int OPC_W  = 8;
  localparam int REG_W  = 4;
  localparam int OFF_W  = 16;
  localparam int IMM_W  = 32;
  localparam int XLEN   = 64;
  localparam int OFF_LO = 2 * OPC_W;
  localparam int IMM_LO = OFF_LO + OFF_W;
  localparam logic [OPC_W-1:0] PAIR_OPC = 8'h18;

  typedef struct packed {
    logic capHold;
    logic capOut;
    logic joinPair;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic [2:0]       cls;
    logic [3:0]       aluCode;
    logic             srcSel;
    logic [2:0]       lsMode;
    logic [1:0]       lsSize;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic [XLEN-1:0]  offset;
    logic [XLEN-1:0]  immSext;
    logic [IMM_W-1:0] immRaw;
    logic [XLEN-1:0]  imm64;
    logic             len2;
    logic             illegal;
  } decoded_t;
endpackage

// File: rtl/pfvm_dec_ctrl.sv
module pfvm_dec_ctrl
  import pfvm_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         outReady,
  input  logic         isPairFirst,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic pending;
  logic accept;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobes.joinPair = pending;
    strobes.capHold  = accept && !pending && isPairFirst;
    strobes.capOut   = accept && (pending || !isPairFirst);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (strobes.capHold)  pending <= 1'b1;
      else if (accept)      pending <= 1'b0;
      if (strobes.capOut)   outValid <= 1'b1;
      else if (outReady)    outValid <= 1'b0;
    end
  end

  // R10: a held first slot never shows up as an output
  a_r10_first_silent: assert property (@(posedge clk) disable iff (rst)
    strobes.capHold |=> (!outValid && pending));

  // R8: a stalled output is not dropped
  a_r8_keep_valid: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/pfvm_dec_path.sv
module pfvm_dec_path
  import pfvm_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bigEndMode,
  input  logic [SLOT_W-1:0] inWord,
  input  ctrlStrobes_t      strobes,
  input  logic              outValid,
  input  logic              outReady,
  output logic              isPairFirst,
  output decoded_t          outBus
);
  logic [SLOT_W-1:0] holdWord;
  logic [SLOT_W-1:0] slotA;
  logic [OPC_W-1:0]  opc;
  logic [2*REG_W-1:0] regByte;
  logic [IMM_W-1:0]  immA;
  logic              isArith;
  decoded_t          dec;

  assign isPairFirst = (inWord[OPC_W-1:0] == PAIR_OPC);
  assign slotA   = strobes.joinPair ? holdWord : inWord;
  assign opc     = slotA[OPC_W-1:0];
  assign regByte = slotA[OFF_LO-1:OPC_W];
  assign immA    = slotA[IMM_LO +: IMM_W];
  assign isArith = opc[2];

  always_comb begin
    dec.opcode  = opc;
    dec.cls     = opc[2:0];
    dec.aluCode = isArith ? opc[7:4] : 4'd0;
    dec.srcSel  = isArith ? opc[3]   : 1'b0;
    dec.lsMode  = isArith ? 3'd0 : opc[7:5];
    dec.lsSize  = isArith ? 2'd0 : opc[4:3];
    if (bigEndMode) begin
      dec.dst = regByte[2*REG_W-1:REG_W];
      dec.src = regByte[REG_W-1:0];
    end else begin
      dec.dst = regByte[REG_W-1:0];
      dec.src = regByte[2*REG_W-1:REG_W];
    end
    dec.offset  = {{(XLEN-OFF_W){slotA[IMM_LO-1]}}, slotA[IMM_LO-1:OFF_LO]};
    dec.immRaw  = immA;
    dec.immSext = {{(XLEN-IMM_W){immA[IMM_W-1]}}, immA};
    dec.len2    = strobes.joinPair;
    dec.imm64   = strobes.joinPair ? {inWord[IMM_LO +: IMM_W], immA} : dec.immSext;
    if (isArith)
      dec.illegal = (opc[7:4] >= 4'hE);
    else
      dec.illegal = (opc[7:5] == 3'd4) || (opc[7:5] == 3'd5) || (opc[7:5] == 3'd7);
    if (strobes.joinPair && (inWord[IMM_LO-1:0] != '0))
      dec.illegal = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.capHold) holdWord <= inWord;
    if (strobes.capOut)  outBus   <= dec;
  end

  // R8: stalled output holds every field
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outBus));

  // R6: a two-slot result always carries the wide-load opcode
  a_r6_pair_opcode: assert property (@(posedge clk) disable iff (rst)
    (outValid && outBus.len2) |-> (outBus.opcode == PAIR_OPC));

  // R7: reserved load/store modes are always flagged
  a_r7_reserved_mode: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outBus.cls[2] && (outBus.lsMode inside {3'd4, 3'd5, 3'd7}))
      |-> outBus.illegal);
endmodule

// File: rtl/pfvm_insn_decoder.sv
module pfvm_insn_decoder
  import pfvm_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bigEndMode,
  input  logic              inValid,
  output logic              inReady,
  input  logic [SLOT_W-1:0] inWord,
  output logic              outValid,
  input  logic              outReady,
  output logic [OPC_W-1:0]  outOpcode,
  output logic [2:0]        outClass,
  output logic [3:0]        outAluCode,
  output logic              outSrcSel,
  output logic [2:0]        outLsMode,
  output logic [1:0]        outLsSize,
  output logic [REG_W-1:0]  outDst,
  output logic [REG_W-1:0]  outSrc,
  output logic [XLEN-1:0]   outOffset,
  output logic [XLEN-1:0]   outImmSext,
  output logic [IMM_W-1:0]  outImmRaw,
  output logic [XLEN-1:0]   outImm64,
  output logic              outLen2,
  output logic              outIllegal
);
  ctrlStrobes_t strobes;
  logic         isPairFirst;
  decoded_t     outBus;

  pfvm_dec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .isPairFirst(isPairFirst), .inReady(inReady), .outValid(outValid),
    .strobes(strobes)
  );

  pfvm_dec_path u_path (
    .clk(clk), .rst(rst), .bigEndMode(bigEndMode), .inWord(inWord),
    .strobes(strobes), .outValid(outValid), .outReady(outReady),
    .isPairFirst(isPairFirst), .outBus(outBus)
  );

  assign outOpcode  = outBus.opcode;
  assign outClass   = outBus.cls;
  assign outAluCode = outBus.aluCode;
  assign outSrcSel  = outBus.srcSel;
  assign outLsMode  = outBus.lsMode;
  assign outLsSize  = outBus.lsSize;
  assign outDst     = outBus.dst;
  assign outSrc     = outBus.src;
  assign outOffset  = outBus.offset;
  assign outImmSext = outBus.immSext;
  assign outImmRaw  = outBus.immRaw;
  assign outImm64   = outBus.imm64;
  assign outLen2    = outBus.len2;
  assign outIllegal = outBus.illegal;
endmodule

// File: tb/pfvm_insn_decoder_bench.sv
module pfvm_insn_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bigEndMode = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [63:0] inWord = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outOpcode;
  logic [2:0] outClass;
  logic [3:0] outAluCode;
  logic outSrcSel;
  logic [2:0] outLsMode;
  logic [1:0] outLsSize;
  logic [3:0] outDst, outSrc;
  logic [63:0] outOffset, outImmSext, outImm64;
  logic [31:0] outImmRaw;
  logic outLen2, outIllegal;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfvm_insn_decoder u_pfvm_insn_decoder (
    .clk(clk), .rst(rst), .bigEndMode(bigEndMode), .inValid(inValid),
    .inReady(inReady), .inWord(inWord), .outValid(outValid), .outReady(outReady),
    .outOpcode(outOpcode), .outClass(outClass), .outAluCode(outAluCode),
    .outSrcSel(outSrcSel), .outLsMode(outLsMode), .outLsSize(outLsSize),
    .outDst(outDst), .outSrc(outSrc), .outOffset(outOffset),
    .outImmSext(outImmSext), .outImmRaw(outImmRaw), .outImm64(outImm64),
    .outLen2(outLen2), .outIllegal(outIllegal)
  );

  typedef struct packed {
    logic [63:0] word;
    logic        mode;
    logic [3:0]  dst;
    logic [3:0]  src;
    logic [3:0]  code;
    logic        sel;
    logic [2:0]  lsm;
    logic [1:0]  lss;
    logic        ill;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{{32'hFFFFFFFE,16'h8000,8'h21,8'h07}, 1'b0, 4'h1, 4'h2, 4'h0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{{32'hFFFFFFFE,16'h8000,8'h21,8'h07}, 1'b1, 4'h2, 4'h1, 4'h0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{{32'h7FFFFFFF,16'h1234,8'h5A,8'hBC}, 1'b0, 4'hA, 4'h5, 4'hB, 1'b1, 3'd0, 2'd0, 1'b0},
    '{{32'h00000010,16'hFFF0,8'h34,8'h5D}, 1'b1, 4'h3, 4'h4, 4'h5, 1'b1, 3'd0, 2'd0, 1'b0},
    '{{32'h80000000,16'h0001,8'h00,8'hE6}, 1'b0, 4'h0, 4'h0, 4'hE, 1'b0, 3'd0, 2'd0, 1'b1},
    '{{32'h00000000,16'h0004,8'h12,8'h61}, 1'b0, 4'h2, 4'h1, 4'h0, 1'b0, 3'd3, 2'd0, 1'b0},
    '{{32'h00000000,16'h7FFF,8'h9F,8'hDB}, 1'b0, 4'hF, 4'h9, 4'h0, 1'b0, 3'd6, 2'd3, 1'b0},
    '{{32'hDEADBEEF,16'hFFFF,8'h0C,8'h72}, 1'b1, 4'h0, 4'hC, 4'h0, 1'b0, 3'd3, 2'd2, 1'b0},
    '{{32'h0000000E,16'h0000,8'h00,8'h28}, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 3'd1, 2'd1, 1'b0},
    '{{32'h00000001,16'h0000,8'h00,8'h80}, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 3'd4, 2'd0, 1'b1},
    '{{32'h00000002,16'h0000,8'h11,8'hA9}, 1'b0, 4'h1, 4'h1, 4'h0, 1'b0, 3'd5, 2'd1, 1'b1},
    '{{32'h00000003,16'h0000,8'h00,8'hE1}, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 3'd7, 2'd0, 1'b1},
    '{{32'h00000004,16'h0000,8'h00,8'hF7}, 1'b0, 4'h0, 4'h0, 4'hF, 1'b0, 3'd0, 2'd0, 1'b1},
    '{{32'h00000010,16'h0000,8'h76,8'hDC}, 1'b0, 4'h6, 4'h7, 4'hD, 1'b1, 3'd0, 2'd0, 1'b0}
  };

  task automatic chk(input string tag, input logic [299:0] got, input logic [299:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] sx16(input logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction
  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic issue(input logic [63:0] w, input logic m);
    @(negedge clk);
    inValid = 1'b1; inWord = w; bigEndMode = m;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9 reset state", {298'd0, outValid, inReady}, {298'd0, 1'b0, 1'b1});

    for (int i = 0; i < NVEC; i++) begin
      vec_t v = VEC[i];
      issue(v.word, v.mode);
      chk("R2/R3/R4/R7 fields",
          {271'd0, outValid, outDst, outSrc, outAluCode, outSrcSel, outLsMode, outLsSize, outIllegal},
          {271'd0, 1'b1, v.dst, v.src, v.code, v.sel, v.lsm, v.lss, v.ill});
      chk("R1/R5/R6 values",
          {4'd0, outOpcode, outClass, outOffset, outImmSext, outImmRaw, outImm64, outLen2},
          {4'd0, v.word[7:0], v.word[2:0], sx16(v.word[31:16]), sx32(v.word[63:32]),
           v.word[63:32], sx32(v.word[63:32]), 1'b0});
    end

    // R10 and R6: clean two-slot load
    issue({32'h89ABCDEF, 16'h0000, 8'h03, 8'h18}, 1'b0);
    chk("R10 no output after first slot", {299'd0, outValid}, {299'd0, 1'b0});
    issue({32'h01234567, 32'h00000000}, 1'b0);
    chk("R6 pair joined",
        {155'd0, outValid, outLen2, outOpcode, outDst, outImm64, outImmRaw, outIllegal, outLsMode, outLsSize},
        {155'd0, 1'b1, 1'b1, 8'h18, 4'h3, 64'h0123456789ABCDEF, 32'h89ABCDEF, 1'b0, 3'd0, 2'd3});
    @(negedge clk);

    // R7: dirty second slot
    issue({32'h00000001, 16'h0000, 8'h00, 8'h18}, 1'b0);
    issue({32'hFFFFFFFF, 32'h00000100}, 1'b0);
    chk("R7 dirty second slot", {296'd0, outValid, outLen2, outIllegal, 1'b0},
        {296'd0, 1'b1, 1'b1, 1'b1, 1'b0});
    @(negedge clk);

    // R8: backpressure
    outReady = 1'b0;
    issue({32'h00000005, 16'h0000, 8'h21, 8'h07}, 1'b0);
    inValid = 1'b1; inWord = {32'h00000006, 16'h0000, 8'h43, 8'hBC};
    @(negedge clk);
    chk("R8 stalled output held", {226'd0, outValid, inReady, outOpcode, outImmSext},
        {226'd0, 1'b1, 1'b0, 8'h07, 64'd5});
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 next slot after release", {226'd0, outValid, inReady, outOpcode, outImmSext},
        {226'd0, 1'b1, 1'b1, 8'hBC, 64'd6});
    @(negedge clk);
    chk("R8 drained", {299'd0, outValid}, {299'd0, 1'b0});

    // R9: reset between the two slots
    issue({32'h0000AAAA, 16'h0000, 8'h00, 8'h18}, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    issue({32'h00000009, 16'h0000, 8'h21, 8'h07}, 1'b0);
    chk("R9 pair discarded by reset", {226'd0, outValid, outLen2, outOpcode, outImm64},
        {226'd0, 1'b1, 1'b0, 8'h07, 64'd9});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule